// File: doc/BRIEF.md
# Serial ADC Conversion and Readout Controller

This block sits on the host side of a serial successive-approximation converter. The converter has a single combined pin that starts a conversion on its rising edge and also frames the serial transfer that follows. When the user side hands over a request, the controller raises that pin and waits a fixed number of system cycles for the conversion to finish. It then runs a frame of 16 serial clocks. During the frame it shifts out a 7-bit configuration word and shifts in the result, most significant bit first.

The user side selects the input channel, single-ended or differential input, the common-return option, unipolar or bipolar coding, sleep, and whether the converter is kept powered between samples. In nap operation the combined pin stays high for the whole conversion. In stay-awake operation the pin returns low a few cycles after the start, well before the first bit decision. A parameter chooses a 12-bit or a 16-bit converter. When the controller wakes the converter from sleep, it discards the waking frame, waits out the wake-up time and converts again before it reports anything.

Top module: `sar_adc_host`

## Requirements
- R1: After reset, adc_cs_o, adc_sck_o, adc_sdi_o and res_valid_o are low and req_ready_o is high.
- R2: A request is accepted only while req_ready_o is high. req_ready_o stays low from acceptance until the cycle res_valid_o is high, and a request held high during that time starts no second conversion.
- R3: In nap operation (stay_awake_i=0), adc_cs_o is high for exactly CONV_CYC cycles from acceptance. adc_sck_o stays low and adc_sdi_o does not change while adc_cs_o is high.
- R4: In stay-awake operation (stay_awake_i=1), adc_cs_o is high for exactly CS_HI_CYC cycles and then stays low. adc_cs_o falls only after CS_HI_CYC or after CONV_CYC high cycles.
- R5: Each frame has exactly 16 serial clock pulses, each high for SCK_HALF_CYC cycles, with the first rising edge SCK_HALF_CYC cycles after the conversion time ends.
- R6: The configuration word is sent with bit 6 first: bit6=single_i, bits5..3=chan_i[2:0], bit2=com_i, bit1=uni_i, bit0=sleep_i. adc_sdi_o holds bit 6-k at rising edge k+1 (k=0..6) and is 0 at rising edges 8 to 16. It changes only while adc_sck_o is low.
- R7: adc_sdo_i is sampled just before each rising serial clock edge, so the MSB that is present when the frame opens is the first bit captured. With RES_BITS=16 all 16 bits form the result. With RES_BITS=12 only the first 12 are kept and the last 4 are ignored.
- R8: res_valid_o is high for one cycle, exactly one cycle after the last falling serial clock edge (latency CONV_CYC+32*SCK_HALF_CYC+1 cycles from acceptance). res_data_o and res_cfg_o hold the captured word and the configuration word sent.
- R9: A frame sent with sleep set marks the converter asleep. A later request with sleep_i=0 runs a discarded frame, waits WAKE_CYC cycles, and then converts again and reports only that second result. The latency is 2*(CONV_CYC+32*SCK_HALF_CYC+1)+WAKE_CYC cycles.
- R10: adc_sdo_i is ignored outside the serial clock frame, so activity on it during conversion does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Conversion request |
| req_ready_o | output | 1 | Controller idle and able to accept a request |
| single_i | input | 1 | Single-ended input select |
| chan_i | input | 3 | Channel select bits |
| com_i | input | 1 | Common-return select |
| uni_i | input | 1 | Unipolar coding select |
| sleep_i | input | 1 | Put converter to sleep after this frame |
| stay_awake_i | input | 1 | 1 keeps converter powered, 0 lets it nap |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | RES_BITS | Captured conversion result |
| res_cfg_o | output | 7 | Configuration word used for the result |
| adc_cs_o | output | 1 | Combined convert-start and frame pin |
| adc_sck_o | output | 1 | Serial clock, idles low |
| adc_sdi_o | output | 1 | Serial configuration data to converter |
| adc_sdo_i | input | 1 | Serial result data from converter |

## Verification
The bound checker watches every cycle for the pin-level rules. It checks that the combined pin falls only in the early window or at the end of the conversion, that the serial clock stays low and data-in stays constant while that pin is high, that data-in never changes while the serial clock is high, that a frame has no more than 16 rising edges, and that the result strobe lasts one cycle and follows a falling serial clock edge. Only the bench scenarios can show the rest. These are that the shifted word carries the right fields in the right order, that the captured value matches what a converter model drives and that the trailing bits of a 12-bit converter are dropped, and that the whole sleep, discard, wait and reconvert sequence reports the right word with the right latency.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

    localparam int CFG_BITS   = 7;
    localparam int FRAME_CLKS = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONV,
        ST_FRAME,
        ST_WAKE
    } host_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HIGH,
        PH_LOW
    } sck_phase_e;

    // Field order is the order the converter decodes the serial word (bit 6 first).
    typedef struct packed {
        logic       se;
        logic [2:0] chan;
        logic       com;
        logic       uni;
        logic       slp;
    } cfg_word_t;

endpackage

// File: rtl/sar_adc_sck_gen.sv
module sar_adc_sck_gen
    import sar_adc_pkg::*;
#(
    parameter int HALF_CYC = 2,
    parameter int NCLK     = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic sck_o,
    output logic rise_o,
    output logic fall_o,
    output logic done_o
);

    localparam int CW = $clog2(HALF_CYC + 1);
    localparam int NW = $clog2(NCLK + 1);

    typedef struct packed {
        sck_phase_e    phase;
        logic [CW-1:0] cnt;
        logic [NW-1:0] nclk;
        logic          sck;
        logic          done;
    } gen_t;

    gen_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        rise_o = 1'b0;
        fall_o = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    d.phase = PH_SETUP;
                    d.cnt   = CW'(HALF_CYC - 1);
                    d.nclk  = '0;
                end
            end
            PH_SETUP, PH_LOW: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else begin
                    rise_o  = 1'b1;
                    d.sck   = 1'b1;
                    d.phase = PH_HIGH;
                    d.cnt   = CW'(HALF_CYC - 1);
                end
            end
            PH_HIGH: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else begin
                    fall_o = 1'b1;
                    d.sck  = 1'b0;
                    if (q.nclk == NW'(NCLK - 1)) begin
                        d.phase = PH_IDLE;
                        d.done  = 1'b1;
                    end else begin
                        d.nclk  = q.nclk + 1'b1;
                        d.phase = PH_LOW;
                        d.cnt   = CW'(HALF_CYC - 1);
                    end
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, cnt: '0, nclk: '0, sck: 1'b0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sck_o  = q.sck;
    assign done_o = q.done;

endmodule

// File: rtl/sar_adc_shift.sv
module sar_adc_shift
    import sar_adc_pkg::*;
#(
    parameter int RES_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [CFG_BITS-1:0] cfg_i,
    input  logic                rise_i,
    input  logic                fall_i,
    input  logic                sdo_i,
    output logic                sdi_o,
    output logic [RES_BITS-1:0] data_o
);

    localparam int RW = $clog2(RES_BITS + 1);

    typedef struct packed {
        logic [CFG_BITS-1:0] tx;
        logic [RES_BITS-1:0] rx;
        logic [RW-1:0]       cnt;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d = q;
        if (load_i) begin
            d.tx  = cfg_i;
            d.rx  = '0;
            d.cnt = '0;
        end else begin
            if (fall_i) begin
                d.tx = {q.tx[CFG_BITS-2:0], 1'b0};
            end
            // Bits beyond the converter resolution are don't-care and dropped.
            if (rise_i && (q.cnt < RW'(RES_BITS))) begin
                d.rx  = {q.rx[RES_BITS-2:0], sdo_i};
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sdi_o  = q.tx[CFG_BITS-1];
    assign data_o = q.rx;

endmodule

// File: rtl/sar_adc_host.sv
module sar_adc_host
    import sar_adc_pkg::*;
#(
    parameter int RES_BITS     = 16,
    parameter int CONV_CYC     = 175,
    parameter int CS_HI_CYC    = 2,
    parameter int WAKE_CYC     = 3_000_000,
    parameter int SCK_HALF_CYC = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid_i,
    output logic                req_ready_o,
    input  logic                single_i,
    input  logic [2:0]          chan_i,
    input  logic                com_i,
    input  logic                uni_i,
    input  logic                sleep_i,
    input  logic                stay_awake_i,
    output logic                res_valid_o,
    output logic [RES_BITS-1:0] res_data_o,
    output logic [6:0]          res_cfg_o,
    output logic                adc_cs_o,
    output logic                adc_sck_o,
    output logic                adc_sdi_o,
    input  logic                adc_sdo_i
);

    localparam int CYC_MAX = (CONV_CYC > WAKE_CYC) ? CONV_CYC : WAKE_CYC;
    localparam int CW      = $clog2(CYC_MAX + 1);

    typedef struct packed {
        host_state_e         state;
        logic [CW-1:0]       cyc;
        cfg_word_t           cfg;
        logic                stay;
        logic                asleep;
        logic                discard;
        logic                cs;
        logic                valid;
        logic [RES_BITS-1:0] res;
        cfg_word_t           res_cfg;
    } host_t;

    host_t q, d;

    logic                fr_start;
    logic                sck_rise;
    logic                sck_fall;
    logic                fr_done;
    logic [RES_BITS-1:0] fr_data;

    sar_adc_sck_gen #(
        .HALF_CYC(SCK_HALF_CYC),
        .NCLK    (FRAME_CLKS)
    ) u_sck (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(fr_start),
        .sck_o  (adc_sck_o),
        .rise_o (sck_rise),
        .fall_o (sck_fall),
        .done_o (fr_done)
    );

    sar_adc_shift #(
        .RES_BITS(RES_BITS)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(fr_start),
        .cfg_i (q.cfg),
        .rise_i(sck_rise),
        .fall_i(sck_fall),
        .sdo_i (adc_sdo_i),
        .sdi_o (adc_sdi_o),
        .data_o(fr_data)
    );

    always_comb begin
        d        = q;
        d.valid  = 1'b0;
        fr_start = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid_i) begin
                    d.cfg.se   = single_i;
                    d.cfg.chan = chan_i;
                    d.cfg.com  = com_i;
                    d.cfg.uni  = uni_i;
                    d.cfg.slp  = sleep_i;
                    d.stay     = stay_awake_i;
                    d.discard  = q.asleep && !sleep_i;
                    d.state    = ST_CONV;
                    d.cyc      = '0;
                    d.cs       = 1'b1;
                end
            end
            ST_CONV: begin
                d.cyc = q.cyc + 1'b1;
                // Stay-awake: drop the pin inside the early window, before any bit decision.
                d.cs  = q.stay ? ((int'(q.cyc) + 1) < CS_HI_CYC) : 1'b1;
                if (q.cyc == CW'(CONV_CYC - 1)) begin
                    d.state  = ST_FRAME;
                    d.cyc    = '0;
                    d.cs     = 1'b0;
                    fr_start = 1'b1;
                end
            end
            ST_FRAME: begin
                if (fr_done) begin
                    if (q.discard) begin
                        d.discard = 1'b0;
                        d.asleep  = 1'b0;
                        d.state   = ST_WAKE;
                        d.cyc     = '0;
                    end else begin
                        d.valid   = 1'b1;
                        d.res     = fr_data;
                        d.res_cfg = q.cfg;
                        d.asleep  = q.cfg.slp;
                        d.state   = ST_IDLE;
                    end
                end
            end
            ST_WAKE: begin
                d.cyc = q.cyc + 1'b1;
                if (q.cyc == CW'(WAKE_CYC - 1)) begin
                    d.state = ST_CONV;
                    d.cyc   = '0;
                    d.cs    = 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, cyc: '0, cfg: '0, stay: 1'b0, asleep: 1'b0,
                   discard: 1'b0, cs: 1'b0, valid: 1'b0, res: '0, res_cfg: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready_o = (q.state == ST_IDLE);
    assign res_valid_o = q.valid;
    assign res_data_o  = q.res;
    assign res_cfg_o   = q.res_cfg;
    assign adc_cs_o    = q.cs;

endmodule

// File: rtl/sar_adc_host_chk.sv
module sar_adc_host_chk
    import sar_adc_pkg::*;
#(
    parameter int CONV_CYC  = 175,
    parameter int CS_HI_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready_o,
    input logic res_valid_o,
    input logic adc_cs_o,
    input logic adc_sck_o,
    input logic adc_sdi_o
);

    logic [31:0] hi_cnt;
    logic [5:0]  rise_cnt;
    logic        cs_p;
    logic        sck_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt   <= '0;
            rise_cnt <= '0;
            cs_p     <= 1'b0;
            sck_p    <= 1'b0;
        end else begin
            cs_p  <= adc_cs_o;
            sck_p <= adc_sck_o;
            if (adc_cs_o && !cs_p) begin
                hi_cnt <= 32'd1;
            end else if (adc_cs_o) begin
                hi_cnt <= hi_cnt + 32'd1;
            end
            if (adc_cs_o) begin
                rise_cnt <= '0;
            end else if (adc_sck_o && !sck_p) begin
                rise_cnt <= rise_cnt + 6'd1;
            end
        end
    end

    assert_cs_fall_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_o) |-> (hi_cnt == 32'(CS_HI_CYC) || hi_cnt == 32'(CONV_CYC)));

    assert_sck_quiet_conv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_o |-> !adc_sck_o);

    assert_sdi_quiet_conv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_cs_o && $past(adc_cs_o)) |-> $stable(adc_sdi_o));

    assert_sdi_sck_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(adc_sdi_o) |-> !adc_sck_o);

    assert_ready_idle_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> (!adc_cs_o && !adc_sck_o));

    assert_frame_clocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_sck_o) |-> (rise_cnt < 6'(FRAME_CLKS)));

    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);

    assert_valid_after_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> ($past(adc_sck_o, 2) && !$past(adc_sck_o)));

endmodule

bind sar_adc_host sar_adc_host_chk #(
    .CONV_CYC (CONV_CYC),
    .CS_HI_CYC(CS_HI_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready_o(req_ready_o),
    .res_valid_o(res_valid_o),
    .adc_cs_o   (adc_cs_o),
    .adc_sck_o  (adc_sck_o),
    .adc_sdi_o  (adc_sdi_o)
);

// File: tb/sim_adc_model.sv
module sim_adc_model #(
    parameter int CONV_CYC = 20,
    parameter int RES_BITS = 16
) (
    input  logic        clk,
    input  logic        cs,
    input  logic        sck,
    input  logic        sdi,
    input  logic [15:0] w_base,
    input  logic        noise,
    output logic        sdo,
    output int          loads,
    output logic [6:0]  cfg_seen,
    output int          rises,
    output int          tail_ones
);

    logic        cs_p = 1'b0;
    logic        sck_p = 1'b0;
    logic        live = 1'b0;
    logic        nz = 1'b0;
    logic [15:0] shreg = '0;
    int          since = 0;
    logic [15:0] w_now;

    initial begin
        loads     = 0;
        rises     = 0;
        tail_ones = 0;
        cfg_seen  = '0;
    end

    always_comb begin
        w_now = 16'(w_base + 16'(loads) * 16'h1111);
    end

    always @(posedge clk) begin
        cs_p  <= cs;
        sck_p <= sck;
        nz    <= ~nz;
        if (cs && !cs_p) begin
            since     <= 1;
            live      <= 1'b0;
            rises     <= 0;
            cfg_seen  <= '0;
            tail_ones <= 0;
        end else if (since != 0) begin
            if (since == CONV_CYC - 1) begin
                since <= 0;
                live  <= 1'b1;
                loads <= loads + 1;
                if (RES_BITS == 12) shreg <= {w_now[11:0], 4'hF};
                else                shreg <= w_now;
            end else begin
                since <= since + 1;
            end
        end
        if (sck && !sck_p) begin
            rises <= rises + 1;
            if (rises < 7) cfg_seen <= {cfg_seen[5:0], sdi};
            else if (sdi)  tail_ones <= tail_ones + 1;
        end
        if (!sck && sck_p && live) begin
            shreg <= {shreg[14:0], 1'b1};
        end
    end

    assign sdo = live ? shreg[15] : (noise & nz);

endmodule

// File: tb/sim_sar_adc_host.sv
`timescale 1ns/1ps
module sim_sar_adc_host;

    localparam int C  = 20;
    localparam int D  = 2;
    localparam int HI = 2;
    localparam int W  = 200;
    localparam int LAT = C + 32 * D + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic       req0 = 1'b0, req1 = 1'b0;
    logic       single = 1'b0, com = 1'b0, uni = 1'b0, slp = 1'b0, stay = 1'b0;
    logic [2:0] chan = '0;
    logic       noise = 1'b0;
    logic [15:0] wb0 = 16'hA5C3, wb1 = 16'h0BAD;

    logic        rdy0, val0, cs0, sck0, sdi0, sdo0;
    logic [15:0] dat0;
    logic [6:0]  rcfg0;
    logic        rdy1, val1, cs1, sck1, sdi1, sdo1;
    logic [11:0] dat1;
    logic [6:0]  rcfg1;
    int          ld0, rs0, tl0, ld1, rs1, tl1;
    logic [6:0]  cs_seen0, cs_seen1;

    sar_adc_host #(.RES_BITS(16), .CONV_CYC(C), .CS_HI_CYC(HI), .WAKE_CYC(W), .SCK_HALF_CYC(D)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req0), .req_ready_o(rdy0),
        .single_i(single), .chan_i(chan), .com_i(com), .uni_i(uni), .sleep_i(slp),
        .stay_awake_i(stay), .res_valid_o(val0), .res_data_o(dat0), .res_cfg_o(rcfg0),
        .adc_cs_o(cs0), .adc_sck_o(sck0), .adc_sdi_o(sdi0), .adc_sdo_i(sdo0));

    sar_adc_host #(.RES_BITS(12), .CONV_CYC(C), .CS_HI_CYC(HI), .WAKE_CYC(W), .SCK_HALF_CYC(D)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req1), .req_ready_o(rdy1),
        .single_i(single), .chan_i(chan), .com_i(com), .uni_i(uni), .sleep_i(slp),
        .stay_awake_i(stay), .res_valid_o(val1), .res_data_o(dat1), .res_cfg_o(rcfg1),
        .adc_cs_o(cs1), .adc_sck_o(sck1), .adc_sdi_o(sdi1), .adc_sdo_i(sdo1));

    sim_adc_model #(.CONV_CYC(C), .RES_BITS(16)) m0 (
        .clk(clk), .cs(cs0), .sck(sck0), .sdi(sdi0), .w_base(wb0), .noise(noise), .sdo(sdo0),
        .loads(ld0), .cfg_seen(cs_seen0), .rises(rs0), .tail_ones(tl0));

    sim_adc_model #(.CONV_CYC(C), .RES_BITS(12)) m1 (
        .clk(clk), .cs(cs1), .sck(sck1), .sdi(sdi1), .w_base(wb1), .noise(noise), .sdo(sdo1),
        .loads(ld1), .cfg_seen(cs_seen1), .rises(rs1), .tail_ones(tl1));

    int n_chk = 0, n_fail = 0;
    bit timeout = 1'b0;

    // Results of the last run0 call.
    int          r_lat, r_vcnt, r_cshi, r_sckhi, r_csrise, r_rdybusy;
    logic [15:0] r_data;
    logic [6:0]  r_cfg;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [6:0] c, input bit s);
        single = c[6]; chan = c[5:3]; com = c[2]; uni = c[1]; slp = c[0]; stay = s;
    endtask

    task automatic run0(input logic [6:0] c, input bit s, input bit hold);
        int n;
        bit pcs;
        @(negedge clk);
        set_cfg(c, s);
        req0 = 1'b1;
        @(posedge clk);
        n = 0; pcs = 1'b0;
        r_lat = -1; r_vcnt = 0; r_cshi = 0; r_sckhi = 0; r_csrise = 0; r_rdybusy = 0;
        r_data = '0; r_cfg = '0;
        while (n < 2000) begin
            @(negedge clk);
            if (!hold || val0) req0 = 1'b0;
            if (cs0) r_cshi++;
            if (sck0) r_sckhi++;
            if (cs0 && !pcs) r_csrise++;
            pcs = cs0;
            if (r_lat < 0 && !val0 && rdy0) r_rdybusy++;
            if (val0) begin
                r_vcnt++;
                if (r_lat < 0) begin
                    r_lat = n; r_data = dat0; r_cfg = rcfg0;
                end
            end
            if (r_lat >= 0 && n >= r_lat + 5) break;
            @(posedge clk);
            n++;
        end
        req0 = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(rdy0 == 1'b1, "R1 ready", rdy0, 1);
        chk(cs0 == 1'b0 && sck0 == 1'b0 && sdi0 == 1'b0, "R1 pins", {cs0, sck0, sdi0}, 0);
        chk(val0 == 1'b0, "R1 valid", val0, 0);
    endtask

    task automatic t_nap();
        logic [6:0] c = 7'b1_010_0_1_0;
        logic [15:0] exp = 16'(wb0 + 16'(ld0) * 16'h1111);
        run0(c, 1'b0, 1'b0);
        chk(r_cshi == C, "R3 cs high cycles", r_cshi, C);
        chk(r_sckhi == 16 * D, "R5 sck high cycles", r_sckhi, 16 * D);
        chk(rs0 == 16, "R5 rising edges", rs0, 16);
        chk(cs_seen0 == c, "R6 cfg on sdi", cs_seen0, c);
        chk(tl0 == 0, "R6 sdi tail zero", tl0, 0);
        chk(r_data == exp, "R7 data", r_data, exp);
        chk(r_cfg == c, "R8 cfg out", r_cfg, c);
        chk(r_lat == LAT, "R8 latency", r_lat, LAT);
        chk(r_vcnt == 1, "R8 one strobe", r_vcnt, 1);
    endtask

    task automatic t_stay();
        logic [6:0] c = 7'b0_101_1_0_0;
        logic [15:0] exp = 16'(wb0 + 16'(ld0) * 16'h1111);
        run0(c, 1'b1, 1'b0);
        chk(r_cshi == HI, "R4 cs high cycles", r_cshi, HI);
        chk(r_csrise == 1, "R4 single cs pulse", r_csrise, 1);
        chk(cs_seen0 == c, "R6 cfg stay", cs_seen0, c);
        chk(r_data == exp, "R7 data stay", r_data, exp);
        chk(r_lat == LAT, "R8 latency stay", r_lat, LAT);
    endtask

    task automatic t_hold();
        logic [15:0] exp = 16'(wb0 + 16'(ld0) * 16'h1111);
        run0(7'b1_111_0_0_0, 1'b0, 1'b1);
        chk(r_vcnt == 1, "R2 one result while held", r_vcnt, 1);
        chk(r_csrise == 1, "R2 one conversion while held", r_csrise, 1);
        chk(r_rdybusy == 0, "R2 ready low while busy", r_rdybusy, 0);
        chk(r_data == exp, "R2 data", r_data, exp);
    endtask

    task automatic t_noise();
        logic [15:0] exp;
        wb0 = 16'h0000;
        exp = 16'(wb0 + 16'(ld0) * 16'h1111);
        noise = 1'b1;
        run0(7'b0_000_0_0_0, 1'b1, 1'b0);
        noise = 1'b0;
        chk(r_data == exp, "R10 sdo ignored outside frame", r_data, exp);
    endtask

    task automatic t_sleep();
        logic [15:0] exp;
        wb0 = 16'hFFFF;
        exp = 16'(wb0 + 16'(ld0) * 16'h1111);
        run0(7'b1_001_0_0_1, 1'b0, 1'b0);
        chk(r_lat == LAT, "R9 sleep frame latency", r_lat, LAT);
        chk(r_data == exp, "R9 sleep frame data", r_data, exp);
        run0(7'b1_001_0_0_1, 1'b0, 1'b0);
        chk(r_lat == LAT && r_csrise == 1, "R9 sleep again no wake", r_lat, LAT);
        exp = 16'(wb0 + 16'(ld0 + 1) * 16'h1111);
        run0(7'b1_011_0_1_0, 1'b0, 1'b0);
        chk(r_lat == 2 * LAT + W, "R9 wake latency", r_lat, 2 * LAT + W);
        chk(r_csrise == 2, "R9 two conversions", r_csrise, 2);
        chk(r_vcnt == 1, "R9 one result", r_vcnt, 1);
        chk(r_data == exp, "R9 second result reported", r_data, exp);
        run0(7'b1_011_0_1_0, 1'b0, 1'b0);
        chk(r_lat == LAT, "R9 awake afterwards", r_lat, LAT);
    endtask

    task automatic t_res12();
        logic [15:0] w = 16'(wb1 + 16'(ld1) * 16'h1111);
        int n = 0;
        bit got = 1'b0;
        logic [11:0] d = '0;
        @(negedge clk);
        set_cfg(7'b1_100_0_1_0, 1'b0);
        req1 = 1'b1;
        @(posedge clk);
        while (n < 500 && !got) begin
            @(negedge clk);
            req1 = 1'b0;
            if (val1) begin got = 1'b1; d = dat1; end
            @(posedge clk);
            n++;
        end
        chk(got, "R7 12-bit result strobe", got, 1);
        chk(d == w[11:0], "R7 12-bit data, tail ignored", d, w[11:0]);
        chk(rs1 == 16, "R5 12-bit frame clocks", rs1, 16);
    endtask

    task automatic main_seq();
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_nap();
        t_stay();
        t_hold();
        t_noise();
        t_sleep();
        t_res12();
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (150000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=done");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule